// File: doc/BRIEF.md
# Strobed DDS Phase Accumulator Core

This core is a direct digital synthesizer that runs on a fast sample clock. A 32-bit phase accumulator advances by an active tuning word on every sample edge and wraps modulo 2^32. The output frequency is therefore word × f_clk / 2^32. The top 13 phase bits address an amplitude map, which returns an 11-bit offset-binary sine-shaped code for a downstream converter. The code comes from a parabolic approximation computed in logic, not a stored table. An active-low asynchronous reset returns the phase to zero at once and clears both tuning words.

Tuning words arrive through a slow load interface. An internal divide-by-8 counter creates a load clock, and this clock is driven out on `sync_o` so that external logic can time its word and strobe against it. The strobe is sampled once per load period, where `sync_o` rises, and the word is captured into a holding register. The holding register moves to the active register where `sync_o` falls, so the step size changes on a single defined sample edge and no accumulator update is skipped. A synchronous `sync_i` pulse clears the counter. Several instances that receive the same pulse therefore share one load phase and run in lockstep.

Top module: `dds_core`

## Requirements
- R1: While `rst_ni` is low, without any clock edge, `phase_o` is 0, `amp_o` is midscale 1024 and `sync_o` is 0. Both tuning words are cleared, so the phase stays at 0 after reset until a word is loaded.
- R2: On every sample edge the accumulator adds the active word modulo 2^32. `phase_o` shows the accumulator.
- R3: The load counter counts 0 to 7 and advances by one on every edge. `sync_o` is 0 for counts 0–3 and 1 for counts 4–7, giving a 4-low/4-high square wave.
- R4: `strb_i` is sampled only at the edge that moves the counter from 3 to 4 (where `sync_o` rises). At that edge, if `strb_i` is 1, `word_i` is captured into the holding register. A strobe at any other edge has no effect.
- R5: A captured word becomes active at the edge that moves the counter from 7 to 0. The accumulator uses the old word at that edge and the new word from the next edge onward. One load per 8 sample clocks is supported.
- R6: `sync_i` high at an edge forces the counter to 0, so `sync_o` is 0 after that edge. At the 3-to-4 edge, `sync_i` takes priority over the strobe, and no word is captured.
- R7: The amplitude address is `phase[31:19]`. Let x = address bits [11:0], and let m = min((x·(4096−x))>>12, 1023). `amp_o` is 1024+m when address bit 12 is 0 and 1024−m when it is 1.
- R8: `amp_o` after edge t is the map of `phase_o` after edge t−2, a fixed latency of 2 cycles.
- R9: Two instances that start out of step, then receive the same `sync_i` pulse and the same loads, produce identical `phase_o`, `amp_o` and `sync_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_i | input | 32 | Tuning word for the load interface |
| strb_i | input | 1 | Load strobe, sampled where sync_o rises |
| sync_i | input | 1 | Synchronous clear of the divide-by-8 counter |
| sync_o | output | 1 | Divided load clock |
| phase_o | output | 32 | Phase accumulator value |
| amp_o | output | 11 | Offset-binary amplitude code |

## Verification
A counter realignment and a strobe sample can fall on the same edge, when `sync_i` is asserted just as the counter reaches 3 and `strb_i` is high. The bench provokes this collision with a new word on the bus. It then checks that `sync_o` stays low after the edge and that the phase increment keeps its old value through the following transfer point. Load timing is judged by measuring the phase increment at the edges on both sides of the 7-to-0 transfer edge.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned PHASE_W  = 32;
  localparam int unsigned ADDR_W   = 13;
  localparam int unsigned AMP_W    = 11;
  localparam int unsigned DIV_LOG2 = 3;
endpackage

// File: rtl/dds_load_ctrl.sv
module dds_load_ctrl #(
  parameter int unsigned PW = 32,
  parameter int unsigned DL = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] word_i,
  input  logic          strb_i,
  input  logic          sync_i,
  output logic          sync_o,
  output logic [PW-1:0] step_o
);
  localparam logic [DL-1:0] CNT_RISE = DL'((1 << (DL - 1)) - 1);
  localparam logic [DL-1:0] CNT_LAST = '1;

  logic [DL-1:0] cnt_q;
  logic [PW-1:0] hold_q, act_q;
  logic          pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      hold_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q <= sync_i ? '0 : cnt_q + 1'b1;
      // sync wins over the strobe sample point
      if (!sync_i && strb_i && cnt_q == CNT_RISE) begin
        hold_q <= word_i;
        pend_q <= 1'b1;
      end else if (pend_q && cnt_q == CNT_LAST) begin
        act_q  <= hold_q;
        pend_q <= 1'b0;
      end
    end
  end

  assign sync_o = cnt_q[DL-1];
  assign step_o = act_q;

  p_sync_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> (cnt_q == '0 && !sync_o));

  p_rise_point_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_o) |-> ($past(cnt_q) == CNT_RISE));

  p_hold_on_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(hold_q) |-> ($past(strb_i) && !$past(sync_i) && $past(cnt_q) == CNT_RISE));

  p_act_on_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_o) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int unsigned PW = 32,
  parameter int unsigned AW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] step_i,
  output logic [PW-1:0] phase_o,
  output logic [AW-1:0] addr_o
);
  logic [PW-1:0] acc_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      acc_q  <= acc_q + step_i;
      addr_q <= acc_q[PW-1 -: AW];
    end
  end

  assign phase_o = acc_q;
  assign addr_o  = addr_q;
endmodule

// File: rtl/dds_amp_map.sv
module dds_amp_map #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] amp_o
);
  localparam int unsigned HW = AW - 1;
  localparam int unsigned PRW = 2 * HW + 1;
  localparam int unsigned SH = 2 * HW - 2 - (DW - 1);
  localparam logic [DW-2:0] MAXV = '1;
  localparam logic [PRW-1:0] MAXL = PRW'(MAXV);
  localparam logic [DW-1:0] MID = {1'b1, {(DW - 1){1'b0}}};

  logic [HW-1:0]  x;
  logic [HW:0]    xc;
  logic [PRW-1:0] prod, mag_full;
  logic [DW-2:0]  mag;
  logic [DW-1:0]  amp_d, amp_q;

  always_comb begin
    x        = addr_i[HW-1:0];
    xc       = {1'b1, {HW{1'b0}}} - {1'b0, x};
    prod     = {{(HW + 1){1'b0}}, x} * {{HW{1'b0}}, xc};
    mag_full = prod >> SH;
    mag      = (mag_full > MAXL) ? MAXV : mag_full[DW-2:0];
    amp_d    = addr_i[HW] ? MID - {1'b0, mag} : MID + {1'b0, mag};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) amp_q <= MID;
    else         amp_q <= amp_d;
  end

  assign amp_o = amp_q;

  p_no_zero_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_o != '0);
endmodule

// File: rtl/dds_core.sv
module dds_core
  import dds_pkg::*;
#(
  parameter int unsigned PW = PHASE_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = AMP_W,
  parameter int unsigned DL = DIV_LOG2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] word_i,
  input  logic          strb_i,
  input  logic          sync_i,
  output logic          sync_o,
  output logic [PW-1:0] phase_o,
  output logic [DW-1:0] amp_o
);
  logic [PW-1:0] step_w;
  logic [AW-1:0] addr_w;

  dds_load_ctrl #(.PW(PW), .DL(DL)) u_load (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .word_i(word_i),
    .strb_i(strb_i),
    .sync_i(sync_i),
    .sync_o(sync_o),
    .step_o(step_w)
  );

  dds_phase_acc #(.PW(PW), .AW(AW)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_w),
    .phase_o(phase_o),
    .addr_o (addr_w)
  );

  dds_amp_map #(.AW(AW), .DW(DW)) u_amp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .addr_i(addr_w),
    .amp_o (amp_o)
  );

  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o == $past(phase_o) + $past(step_w));

  p_reset_phase_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (phase_o == '0));
endmodule

// File: tb/tb_dds_core.sv
`timescale 1ns/1ps
module tb_dds_core;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rst_b = 1'b0;
  logic [31:0] word_i = '0;
  logic        strb_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        sync_o, sync_b;
  logic [31:0] phase_o, phase_b;
  logic [10:0] amp_o, amp_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  dds_core dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .word_i(word_i), .strb_i(strb_i),
    .sync_i(sync_i), .sync_o(sync_o), .phase_o(phase_o), .amp_o(amp_o)
  );

  dds_core dut_b (
    .clk_i(clk_i), .rst_ni(rst_b), .word_i(word_i), .strb_i(strb_i),
    .sync_i(sync_i), .sync_o(sync_b), .phase_o(phase_b), .amp_o(amp_b)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [10:0] amp_ref(input logic [31:0] p);
    int x, v;
    x = int'(p[30:19]);
    v = (x * (4096 - x)) >>> 12;
    if (v > 1023) v = 1023;
    return p[31] ? 11'(1024 - v) : 11'(1024 + v);
  endfunction

  task automatic sync_pulse();
    sync_i = 1'b1;
    step();
    sync_i = 1'b0;
  endtask

  // sync at edge k, strobe sampled at k+4, transfer at k+8
  task automatic load_word(input logic [31:0] w, input logic [31:0] old, input string tag);
    logic [31:0] p7, p8, p9;
    sync_pulse();
    word_i = w;
    strb_i = 1'b1;
    repeat (4) step();
    strb_i = 1'b0;
    repeat (3) step();
    p7 = phase_o;
    step();
    p8 = phase_o;
    step();
    p9 = phase_o;
    chk({tag, " R5 old step at transfer edge"}, p8 - p7, old);
    chk({tag, " R5 new step after transfer"}, p9 - p8, w);
  endtask

  task automatic run_amp(input int n, input string tag);
    logic [31:0] ph_a, ph_b;
    ph_a = phase_o;
    step();
    ph_b = phase_o;
    for (int i = 0; i < n; i++) begin
      step();
      chk({tag, " R8 R7 amp latency"}, 32'(amp_o), 32'(amp_ref(ph_a)));
      ph_a = ph_b;
      ph_b = phase_o;
    end
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; rst_b = 1'b0;
    repeat (2) step();
    rst_ni = 1'b1; rst_b = 1'b1;
    repeat (5) step();
    chk("R1 phase zero after reset", phase_o, 32'h0);
    chk("R1 amp midscale after reset", 32'(amp_o), 32'd1024);
  endtask

  task automatic t_sync_wave();
    sync_pulse();
    for (int n = 1; n <= 8; n++) begin
      step();
      chk("R3 sync_o pattern", 32'(sync_o), ((n % 8) >= 4) ? 32'd1 : 32'd0);
    end
  endtask

  task automatic t_amp_quarter();
    load_word(32'h4000_0000, 32'h0, "quarter");
    step(); chk("R7 amp at phase 0", 32'(amp_o), 32'd1024);
    step(); chk("R7 amp at quarter", 32'(amp_o), 32'd2047);
    step(); chk("R7 amp at half", 32'(amp_o), 32'd1024);
    step(); chk("R7 amp at three quarter", 32'(amp_o), 32'd1);
  endtask

  task automatic t_wrap();
    logic [31:0] p0;
    load_word(32'hC000_0000, 32'h4000_0000, "wrap");
    p0 = phase_o;
    repeat (5) step();
    chk("R2 modulo wrap", phase_o, p0 + 32'hC000_0000 * 5);
  endtask

  task automatic t_odd_word();
    load_word(32'h0123_4567, 32'hC000_0000, "odd");
    run_amp(24, "odd");
    load_word(32'h0765_4321, 32'h0123_4567, "back2back");
  endtask

  task automatic t_stray_strobe();
    logic [31:0] pa, pb, pc;
    sync_pulse();
    step();
    word_i = 32'h1111_1111;
    strb_i = 1'b1;
    step();
    strb_i = 1'b0;
    repeat (6) step();
    pa = phase_o; step(); pb = phase_o; step(); pc = phase_o;
    chk("R4 stray strobe ignored a", pb - pa, 32'h0765_4321);
    chk("R4 stray strobe ignored b", pc - pb, 32'h0765_4321);
  endtask

  task automatic t_collision();
    logic [31:0] pa, pb;
    sync_pulse();
    repeat (3) step();
    word_i = 32'h2222_2222;
    strb_i = 1'b1;
    sync_i = 1'b1;
    step();
    strb_i = 1'b0;
    sync_i = 1'b0;
    chk("R6 sync wins, sync_o low", 32'(sync_o), 32'd0);
    repeat (9) step();
    pa = phase_o; step(); pb = phase_o;
    chk("R6 no capture on collision", pb - pa, 32'h0765_4321);
  endtask

  task automatic t_async_reset();
    rst_ni = 1'b0;
    #1;
    chk("R1 async phase", phase_o, 32'h0);
    chk("R1 async amp", 32'(amp_o), 32'd1024);
    chk("R1 async sync_o", 32'(sync_o), 32'd0);
    step();
    rst_ni = 1'b1;
    repeat (3) step();
    chk("R1 words cleared, phase held", phase_o, 32'h0);
  endtask

  task automatic t_lockstep();
    int diff, mism;
    rst_ni = 1'b0; rst_b = 1'b0;
    repeat (2) step();
    rst_ni = 1'b1;
    repeat (3) step();
    rst_b = 1'b1;
    diff = 0;
    for (int i = 0; i < 8; i++) begin
      step();
      if (sync_o != sync_b) diff++;
    end
    chk("R9 instances start out of step", 32'(diff != 0), 32'd1);
    load_word(32'h0ABC_DEF1, 32'h0, "lockstep");
    mism = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (phase_o != phase_b || amp_o != amp_b || sync_o != sync_b) mism++;
    end
    chk("R9 lockstep outputs identical", 32'(mism), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_sync_wave();
    t_amp_quarter();
    t_wrap();
    t_odd_word();
    t_stray_strobe();
    t_collision();
    t_async_reset();
    t_lockstep();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule